// File: doc/BRIEF.md
# Plant Mode Tracking Automaton

This block follows the discrete operating mode of a controlled plant. It holds a small programmable state machine. Each step of that machine looks at two things: a vector of binary plant signals, and a set of digitised control values taken from a neural engine. Each control value is compared with its own programmable limit. The binary signals and the compare flags together form a condition vector. A rule table is scanned against that vector and the current state, and it yields the next state.

Each state names one weight-bank index, which selects the whole weight matrix the neural engine applies. Each state also names a set of binary plant outputs. A typical use gives an actuator one state for a forward step and one for a backward step, so that a state change swaps the weight set.

Evaluation is paced by a slow enable tick, typically 100 Hz to 1 kHz. Between ticks the state is frozen. When the state changes, a one-cycle pulse tells the weight refresh logic that a new bank index is present. All limits, rules and per-state settings are loaded through a single register-write port.

Top module: `mode_tracker`

## Requirements
- R1: While rst_ni is low and right after it is released: state_o is 0, bank_change_o is 0 and plant_o is 0. Every rule is invalid. Every threshold holds 255, so no compare flag can be raised even by a control value of 255.
- R2: For each channel c, the compare flag is 1 exactly when the unsigned control value ctrl_i[8c+7:8c] is strictly greater than the threshold of c. A value equal to the threshold gives 0.
- R3: The condition vector has the plant inputs plant_i[7:0] in bits 7..0 and the compare flag of channel c in bit 8+c. A rule matches when every bit set in its care mask equals the same bit of its match value, and bits not in the care mask are ignored.
- R4: When several valid rules match, the rule with the lowest index decides the next state.
- R5: When no rule matches on a tick, the state is held and no bank_change_o pulse occurs.
- R6: The state changes only on a clock edge where tick_i is 1. Matching conditions without a tick have no effect.
- R7: When a tick moves the state to a different value, bank_change_o is 1 for exactly the following cycle. A rule whose next state equals the current state gives no pulse.
- R8: bank_o and plant_o show the bank index and output pattern stored for the current state. After reset, the bank index of state s is s and its output pattern is 0.
- R9: Register map: wr_addr_i[5:4] selects the region and wr_addr_i[3:0] the index. Region 0 is a threshold in data[7:0]. Region 1 is a state setting, with the bank in data[3:0] and the outputs in data[15:8]. Region 2 is a rule condition, with the care mask in data[15:0] and the match value in data[31:16]. Region 3 is a rule control word, with the source state in data[3:0], the next state in data[11:8] and valid in data[16]. A rule whose valid bit is 0 never matches.
- R10: A rule applies only while the current state equals its source state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Evaluation enable, one cycle per step |
| plant_i | input | NUM_IN | Binary plant signals |
| ctrl_i | input | NUM_CH*CMP_W | Digitised control values, channel c at [c*CMP_W +: CMP_W] |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register write address |
| wr_data_i | input | 32 | Register write data |
| state_o | output | STATE_W | Current automaton state |
| bank_o | output | BANK_W | Weight-bank index of the current state |
| bank_change_o | output | 1 | One-cycle pulse after a state change |
| plant_o | output | NUM_OUT | Binary plant outputs of the current state |

## Verification
The bench builds the block with its default parameters: 16 states, 16 rules, 8 binary inputs, 8 compare channels of 8 bits, and 4-bit bank indices. At that size a single rule chain can walk through every state and check each bank index and output pattern. The 256-value sweeps over one control channel and over the binary inputs check the strict compare boundary and the masked match bit by bit. Boundary values on every channel, and every input combination of a two-rule conflict, check the per-channel thresholds and the priority order.

// File: rtl/mode_pkg.sv
package mode_pkg;
  localparam int ADDR_W  = 6;
  localparam int WDATA_W = 32;
  localparam int IDX_W   = 4;

  typedef enum logic [1:0] {
    RG_THR   = 2'd0,
    RG_STATE = 2'd1,
    RG_COND  = 2'd2,
    RG_CTRL  = 2'd3
  } region_e;
endpackage

// File: rtl/mode_cfg_regs.sv
module mode_cfg_regs
  import mode_pkg::*;
#(
  parameter int NUM_STATES = 16,
  parameter int NUM_CH     = 8,
  parameter int NUM_RULES  = 16,
  parameter int CMP_W      = 8,
  parameter int BANK_W     = 4,
  parameter int NUM_OUT    = 8,
  parameter int COND_W     = 16,
  parameter int STATE_W    = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [WDATA_W-1:0]            wr_data_i,
  output logic [NUM_CH*CMP_W-1:0]       thr_o,
  output logic [NUM_STATES*BANK_W-1:0]  bank_map_o,
  output logic [NUM_STATES*NUM_OUT-1:0] out_map_o,
  output logic [NUM_RULES*COND_W-1:0]   care_o,
  output logic [NUM_RULES*COND_W-1:0]   match_o,
  output logic [NUM_RULES*STATE_W-1:0]  src_o,
  output logic [NUM_RULES*STATE_W-1:0]  next_o,
  output logic [NUM_RULES-1:0]          valid_o
);
  region_e          rg;
  logic [IDX_W-1:0] idx;
  logic             unused_bits;

  assign rg          = region_e'(wr_addr_i[5:4]);
  assign idx         = wr_addr_i[IDX_W-1:0];
  assign unused_bits = ^wr_data_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_thr
    logic [CMP_W-1:0] thr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) thr_q <= '1;
      else if (wr_en_i && rg == RG_THR && idx == IDX_W'(c))
        thr_q <= wr_data_i[CMP_W-1:0];
    end
    assign thr_o[c*CMP_W +: CMP_W] = thr_q;
  end

  for (genvar s = 0; s < NUM_STATES; s++) begin : g_state
    logic [BANK_W-1:0]  bank_q;
    logic [NUM_OUT-1:0] out_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bank_q <= BANK_W'(s);
        out_q  <= '0;
      end else if (wr_en_i && rg == RG_STATE && idx == IDX_W'(s)) begin
        bank_q <= wr_data_i[BANK_W-1:0];
        out_q  <= wr_data_i[8 +: NUM_OUT];
      end
    end
    assign bank_map_o[s*BANK_W +: BANK_W]  = bank_q;
    assign out_map_o[s*NUM_OUT +: NUM_OUT] = out_q;
  end

  for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
    logic [COND_W-1:0]  care_q, match_q;
    logic [STATE_W-1:0] src_q, next_q;
    logic               valid_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        care_q  <= '0;
        match_q <= '0;
      end else if (wr_en_i && rg == RG_COND && idx == IDX_W'(r)) begin
        care_q  <= wr_data_i[COND_W-1:0];
        match_q <= wr_data_i[16 +: COND_W];
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_q   <= '0;
        next_q  <= '0;
        valid_q <= 1'b0;
      end else if (wr_en_i && rg == RG_CTRL && idx == IDX_W'(r)) begin
        src_q   <= wr_data_i[STATE_W-1:0];
        next_q  <= wr_data_i[8 +: STATE_W];
        valid_q <= wr_data_i[16];
      end
    end
    assign care_o[r*COND_W +: COND_W]    = care_q;
    assign match_o[r*COND_W +: COND_W]   = match_q;
    assign src_o[r*STATE_W +: STATE_W]   = src_q;
    assign next_o[r*STATE_W +: STATE_W]  = next_q;
    assign valid_o[r]                    = valid_q;
  end
endmodule

// File: rtl/mode_cond_gen.sv
module mode_cond_gen #(
  parameter int NUM_IN = 8,
  parameter int NUM_CH = 8,
  parameter int CMP_W  = 8
) (
  input  logic [NUM_IN-1:0]       plant_i,
  input  logic [NUM_CH*CMP_W-1:0] ctrl_i,
  input  logic [NUM_CH*CMP_W-1:0] thr_i,
  output logic [NUM_IN+NUM_CH-1:0] cond_o
);
  logic [NUM_CH-1:0] flag;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    assign flag[c] = ctrl_i[c*CMP_W +: CMP_W] > thr_i[c*CMP_W +: CMP_W];
  end

  assign cond_o = {flag, plant_i};
endmodule

// File: rtl/mode_rule_sel.sv
module mode_rule_sel #(
  parameter int NUM_RULES = 16,
  parameter int COND_W    = 16,
  parameter int STATE_W   = 4
) (
  input  logic [STATE_W-1:0]           state_i,
  input  logic [COND_W-1:0]            cond_i,
  input  logic [NUM_RULES*COND_W-1:0]  care_i,
  input  logic [NUM_RULES*COND_W-1:0]  match_i,
  input  logic [NUM_RULES*STATE_W-1:0] src_i,
  input  logic [NUM_RULES*STATE_W-1:0] next_i,
  input  logic [NUM_RULES-1:0]         valid_i,
  output logic                         hit_o,
  output logic [STATE_W-1:0]           next_o
);
  logic [NUM_RULES-1:0] hit_vec;

  for (genvar r = 0; r < NUM_RULES; r++) begin : g_match
    assign hit_vec[r] = valid_i[r]
                      && (src_i[r*STATE_W +: STATE_W] == state_i)
                      && (((cond_i ^ match_i[r*COND_W +: COND_W])
                           & care_i[r*COND_W +: COND_W]) == '0);
  end

  // descending scan so the lowest index is written last and wins
  always_comb begin
    hit_o  = 1'b0;
    next_o = state_i;
    for (int r = NUM_RULES - 1; r >= 0; r--) begin
      if (hit_vec[r]) begin
        hit_o  = 1'b1;
        next_o = next_i[r*STATE_W +: STATE_W];
      end
    end
  end
endmodule

// File: rtl/mode_tracker.sv
module mode_tracker
  import mode_pkg::*;
#(
  parameter int NUM_STATES = 16,
  parameter int NUM_IN     = 8,
  parameter int NUM_CH     = 8,
  parameter int CMP_W      = 8,
  parameter int NUM_RULES  = 16,
  parameter int BANK_W     = 4,
  parameter int NUM_OUT    = 8,
  localparam int STATE_W   = $clog2(NUM_STATES),
  localparam int COND_W    = NUM_IN + NUM_CH
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic [NUM_IN-1:0]       plant_i,
  input  logic [NUM_CH*CMP_W-1:0] ctrl_i,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [WDATA_W-1:0]      wr_data_i,
  output logic [STATE_W-1:0]      state_o,
  output logic [BANK_W-1:0]       bank_o,
  output logic                    bank_change_o,
  output logic [NUM_OUT-1:0]      plant_o
);
  logic [NUM_CH*CMP_W-1:0]       thr;
  logic [NUM_STATES*BANK_W-1:0]  bank_map;
  logic [NUM_STATES*NUM_OUT-1:0] out_map;
  logic [NUM_RULES*COND_W-1:0]   care, match;
  logic [NUM_RULES*STATE_W-1:0]  src, nxt;
  logic [NUM_RULES-1:0]          valid;
  logic [COND_W-1:0]             cond;
  logic                          rule_hit;
  logic [STATE_W-1:0]            rule_next;
  logic [STATE_W-1:0]            state_q;
  logic                          chg_q;

  mode_cfg_regs #(
    .NUM_STATES(NUM_STATES), .NUM_CH(NUM_CH), .NUM_RULES(NUM_RULES),
    .CMP_W(CMP_W), .BANK_W(BANK_W), .NUM_OUT(NUM_OUT),
    .COND_W(COND_W), .STATE_W(STATE_W)
  ) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .thr_o(thr), .bank_map_o(bank_map), .out_map_o(out_map),
    .care_o(care), .match_o(match), .src_o(src), .next_o(nxt),
    .valid_o(valid)
  );

  mode_cond_gen #(.NUM_IN(NUM_IN), .NUM_CH(NUM_CH), .CMP_W(CMP_W)) u_cond (
    .plant_i, .ctrl_i, .thr_i(thr), .cond_o(cond)
  );

  mode_rule_sel #(.NUM_RULES(NUM_RULES), .COND_W(COND_W), .STATE_W(STATE_W)) u_sel (
    .state_i(state_q), .cond_i(cond), .care_i(care), .match_i(match),
    .src_i(src), .next_i(nxt), .valid_i(valid),
    .hit_o(rule_hit), .next_o(rule_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      chg_q   <= 1'b0;
    end else if (tick_i && rule_hit && rule_next != state_q) begin
      state_q <= rule_next;
      chg_q   <= 1'b1;
    end else begin
      chg_q   <= 1'b0;
    end
  end

  assign state_o       = state_q;
  assign bank_change_o = chg_q;
  assign bank_o        = bank_map[state_q*BANK_W +: BANK_W];
  assign plant_o       = out_map[state_q*NUM_OUT +: NUM_OUT];
endmodule

// File: rtl/mode_tracker_chk.sv
module mode_tracker_chk #(
  parameter int STATE_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic               hit_i,
  input logic [STATE_W-1:0] state_i,
  input logic               bank_change_i
);
  p_reset_state_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (state_i == '0 && !bank_change_i));

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(state_i));

  p_nomatch_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !hit_i) |=> ($stable(state_i) && !bank_change_i));

  p_pulse_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_change_i |-> (state_i != $past(state_i)));

  p_change_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != $past(state_i)) |-> bank_change_i);
endmodule

bind mode_tracker mode_tracker_chk #(.STATE_W(STATE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .hit_i(rule_hit),
  .state_i(state_o), .bank_change_i(bank_change_o)
);

// File: tb/mode_tracker_test.sv
module mode_tracker_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        tick_i = 1'b0;
  logic [7:0]  plant_i = '0;
  logic [63:0] ctrl_i = '0;
  logic        wr_en_i = 1'b0;
  logic [5:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [3:0]  state_o;
  logic [3:0]  bank_o;
  logic        bank_change_o;
  logic [7:0]  plant_o;

  int n_checks = 0;
  int n_err = 0;

  mode_tracker uut (
    .clk_i(clk), .rst_ni, .tick_i, .plant_i, .ctrl_i, .wr_en_i,
    .wr_addr_i, .wr_data_i, .state_o, .bank_o, .bank_change_o, .plant_o
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a[5:0]; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic set_rule(input int r, input int src, input int nxt,
                          input int care, input int mat, input int v);
    wr(32'h20 | r, ((mat & 16'hFFFF) << 16) | (care & 16'hFFFF));
    wr(32'h30 | r, (v << 16) | (nxt << 8) | src);
  endtask

  task automatic clear_rules();
    for (int r = 0; r < 16; r++) wr(32'h30 | r, 0);
  endtask

  task automatic do_tick();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
  endtask

  task automatic set_ch(input int ch, input int v);
    ctrl_i = '0;
    ctrl_i[ch*8 +: 8] = v[7:0];
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    #2 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset values, checked while reset is held
    chk("R1", "state in reset", state_o, 0);
    chk("R1", "pulse in reset", bank_change_o, 0);
    chk("R1", "outputs in reset", plant_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "state after reset", state_o, 0);

    // R1: thresholds start at max, so ctrl=255 never raises a flag
    set_rule(0, 0, 5, 32'h0100, 32'h0100, 1);
    ctrl_i = '1;
    do_tick();
    chk("R1", "no flag at max threshold", state_o, 0);
    chk("R5", "no pulse without match", bank_change_o, 0);

    // R2 with threshold 254; R8 reset bank map is identity
    wr(32'h00, 254);
    do_tick();
    chk("R2", "flag fires above threshold", state_o, 5);
    chk("R7", "pulse after change", bank_change_o, 1);
    chk("R8", "reset bank of state 5", bank_o, 5);
    chk("R8", "reset outputs of state 5", plant_o, 0);
    @(negedge clk);
    chk("R7", "pulse lasts one cycle", bank_change_o, 0);
    wr(32'h00, 255);
    ctrl_i = '0;

    // R7 self-loop rule gives no pulse
    clear_rules();
    set_rule(0, 5, 5, 0, 0, 1);
    do_tick();
    chk("R7", "self loop state", state_o, 5);
    chk("R7", "self loop no pulse", bank_change_o, 0);
    set_rule(0, 5, 0, 0, 0, 1);
    do_tick();
    chk("R7", "back to 0", state_o, 0);

    // R8 / R10: per-state maps and an unconditional chain over all states
    for (int s = 0; s < 16; s++)
      wr(32'h10 | s, (((s * 37 + 11) % 256) << 8) | ((s * 7 + 3) % 16));
    for (int r = 0; r < 16; r++) set_rule(r, r, (r + 1) % 16, 0, 0, 1);
    chk("R8", "bank of state 0", bank_o, 3);
    chk("R8", "outputs of state 0", plant_o, 11);
    for (int k = 0; k < 16; k++) begin
      automatic int e = (k + 1) % 16;
      do_tick();
      chk("R10", "chain state", state_o, e);
      chk("R8", "chain bank", bank_o, (e * 7 + 3) % 16);
      chk("R8", "chain outputs", plant_o, (e * 37 + 11) % 256);
      chk("R7", "chain pulse", bank_change_o, 1);
    end

    // R6: matching rules but no tick
    repeat (6) @(negedge clk);
    chk("R6", "held without tick", state_o, 0);
    chk("R6", "no pulse without tick", bank_change_o, 0);

    // R2: per-channel threshold boundary, full sweep on channel 3
    clear_rules();
    set_rule(1, 2, 0, 0, 0, 1);
    for (int c = 0; c < 8; c++) begin
      automatic int th = 100 + c * 10;
      set_rule(0, 0, 2, 1 << (8 + c), 1 << (8 + c), 1);
      wr(c, th);
      for (int v = 0; v < 256; v++) begin
        automatic int e;
        if (c != 3 && (v < th - 1 || v > th + 1)) continue;
        set_ch(c, v);
        e = (v > th) ? 2 : 0;
        do_tick();
        chk("R2", "threshold compare", state_o, e);
        if (e != 0) do_tick();
      end
      wr(c, 255);
    end
    ctrl_i = '0;

    // R3: masked match on binary inputs, care 0x00F0 match 0x00A0
    clear_rules();
    set_rule(0, 0, 3, 32'h00F0, 32'h00A0, 1);
    set_rule(1, 3, 0, 0, 0, 1);
    for (int p = 0; p < 256; p++) begin
      automatic int e = ((p >> 4) == 10) ? 3 : 0;
      plant_i = p[7:0];
      do_tick();
      chk("R3", "binary mask match", state_o, e);
      if (e == 0) chk("R5", "no match no pulse", bank_change_o, 0);
      else do_tick();
    end

    // R3: mixed condition, plant_i[0]==1 and flag of channel 0
    set_rule(0, 0, 3, 32'h0101, 32'h0101, 1);
    wr(0, 50);
    for (int m = 0; m < 4; m++) begin
      automatic int e = (m == 3) ? 3 : 0;
      plant_i = {7'd0, m[0]};
      set_ch(0, m[1] ? 51 : 50);
      do_tick();
      chk("R3", "input and flag combined", state_o, e);
      if (e != 0) do_tick();
    end
    wr(0, 255);
    ctrl_i = '0;

    // R4: priority between two matching rules
    clear_rules();
    set_rule(0, 0, 4, 32'h0001, 32'h0001, 1);
    set_rule(1, 0, 6, 32'h0002, 32'h0002, 1);
    set_rule(2, 4, 0, 0, 0, 1);
    set_rule(3, 6, 0, 0, 0, 1);
    for (int p = 0; p < 4; p++) begin
      automatic int e = p[0] ? 4 : (p[1] ? 6 : 0);
      plant_i = p[7:0];
      do_tick();
      chk("R4", "lowest index wins", state_o, e);
      if (e != 0) do_tick();
    end

    // R9: invalid rule never matches
    set_rule(0, 0, 4, 32'h0001, 32'h0001, 0);
    plant_i = 8'd3;
    do_tick();
    chk("R9", "disabled rule skipped", state_o, 6);
    do_tick();
    plant_i = 8'd1;
    do_tick();
    chk("R9", "disabled rule alone", state_o, 0);

    // R1: asynchronous reset from a nonzero state
    plant_i = 8'd2;
    do_tick();
    chk("R1", "reached state 6", state_o, 6);
    rst_ni = 1'b0;
    #1;
    chk("R1", "reset clears state", state_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    do_tick();
    chk("R1", "rules invalid after reset", state_o, 0);

    finish_run();
  end
endmodule